// File: doc/BRIEF.md
# USB IN Endpoint Control Register

This block keeps the control state of a single USB device IN endpoint and presents it as one 32-bit register on a simple bus. It has a write port (data plus a one-cycle write enable) and a combinational read port. Software uses the register to set the stall response, to pick the transmit FIFO that feeds the endpoint, and to arm or shut down the endpoint. Several bits are command strobes. They set or clear hidden state (the NAK response and the data-sequence bit) and always read back as zero. That hidden state is exported on dedicated status outputs for the endpoint engine.

The endpoint engine sends single-cycle event pulses back into the block: setup complete, transfer complete and disable acknowledge. The enable bit drops on any of these. A disable request runs a fixed ordered sequence. The enable bit is withdrawn first, then the disable bit, and only after that a one-cycle disable-done interrupt is pulsed.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: On a clock edge with `rst_n` low, all state clears: `rd_data` reads 0, `nak_active`, `seq_odd` and `dis_done_irq` are 0, and the disable sequence returns to idle.
- R2: Bit 21 is the stall bit. Every register write loads it from `wr_data[21]` and mirrors it on `stall_active`. Nothing else changes it.
- R3: Bits 25:22 hold the 4-bit transmit FIFO number. They load on every write, read back unchanged and hold when no write occurs.
- R4: Writing 1 to bit 27 sets the NAK state and writing 1 to bit 26 clears it. If both bits are 1, set wins. If neither is 1, the state holds. The new value appears on `nak_active` after the write edge.
- R5: Writing 1 to bit 29 sets the sequence bit to odd (1). Writing 1 to bit 28 sets it to even/DATA0 (0). If both bits are 1, odd wins. If neither is 1, the bit holds. The value appears on `seq_odd`.
- R6: Bits 29:26 and bits 20:0 always read as 0, whatever was written to them.
- R7: Writing 1 to bit 31 sets the enable bit. Writing 0 to bit 31 has no effect on it.
- R8: A pulse on `ev_setup_done` or `ev_xfer_done` clears the enable bit at that edge. The clear wins over a software set in the same cycle.
- R9: Writing 1 to bit 30 sets the disable bit only if the enable bit is already 1 and no disable sequence is in progress. In all other cases, and when 0 is written, the bit is unaffected.
- R10: When `ev_disable_ack` is seen at edge k while the disable bit is 1, the enable bit reads 0 after edge k+1 and the disable bit reads 0 after edge k+2. An acknowledge while no disable is pending is ignored.
- R11: `dis_done_irq` is high for exactly the one cycle after edge k+3. The disable bit is 0 throughout that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| ev_setup_done | input | 1 | Engine pulse: setup phase complete |
| ev_xfer_done | input | 1 | Engine pulse: transfer complete |
| ev_disable_ack | input | 1 | Engine pulse: disable request honoured |
| stall_active | output | 1 | Endpoint answers tokens with STALL |
| nak_active | output | 1 | Endpoint answers tokens with NAK |
| seq_odd | output | 1 | Data sequence: 0 = DATA0/even frame, 1 = odd frame |
| dis_done_irq | output | 1 | One-cycle disable-done interrupt |

## Verification
Writes and engine events take effect on the first clock edge that samples them, so stall, FIFO, NAK, sequence and enable results are due one edge after the stimulus. The disable chain is due at fixed offsets from the acknowledge edge k: enable at k+1, disable at k+2, interrupt at k+3, interrupt gone at k+4. The bench drives inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge. For the disable chain it checks every intermediate edge, so an early or late change is caught in the exact cycle it happens.

// File: rtl/usb_inep_pkg.sv
// Package: usb_inep_pkg
// Holds the register field positions, the decoded write command and the
// disable-sequence states shared by the IN endpoint control blocks.
// Assumes a 32-bit register whose field positions are fixed by software.
package usb_inep_pkg;

    localparam int REG_W        = 32;
    localparam int FIFO_W       = 4;
    localparam int BIT_STALL    = 21;
    localparam int FIFO_LSB     = 22;
    localparam int FIFO_MSB     = FIFO_LSB + FIFO_W - 1;
    localparam int BIT_NAK_CLR  = 26;
    localparam int BIT_NAK_SET  = 27;
    localparam int BIT_SEQ_EVEN = 28;
    localparam int BIT_SEQ_ODD  = 29;
    localparam int BIT_DIS      = 30;
    localparam int BIT_EN       = 31;
    localparam int LOW_MSB      = BIT_STALL - 1;

    // One register write, split into its actions
    typedef struct packed {
        logic              wr;
        logic              stall_val;
        logic [FIFO_W-1:0] fifo_val;
        logic              nak_clr;
        logic              nak_set;
        logic              seq_even;
        logic              seq_odd;
        logic              dis_req;
        logic              en_req;
    } inep_cmd_t;

    // Ordered steps of an endpoint shutdown
    typedef enum logic [2:0] {
        SH_IDLE     = 3'd0,
        SH_PEND     = 3'd1,
        SH_DROP_EN  = 3'd2,
        SH_DROP_DIS = 3'd3,
        SH_RAISE    = 3'd4
    } shut_state_t;

endpackage

// File: rtl/usb_inep_cmd_dec.sv
// Module: usb_inep_cmd_dec
// Splits a register write into per-field load values and one-cycle command
// strobes. Purely combinational. Assumes wr_en lasts one cycle per write.
module usb_inep_cmd_dec
    import usb_inep_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output inep_cmd_t        cmd
);

    logic unused_low_bits;

    // Low bits carry no function; fold them away
    assign unused_low_bits = ^wr_data[LOW_MSB:0];

    // Gate every strobe with the write enable
    always_comb begin
        cmd           = '0;
        cmd.wr        = wr_en;
        cmd.stall_val = wr_data[BIT_STALL];
        cmd.fifo_val  = wr_data[FIFO_MSB:FIFO_LSB];
        cmd.nak_clr   = wr_en & wr_data[BIT_NAK_CLR];
        cmd.nak_set   = wr_en & wr_data[BIT_NAK_SET];
        cmd.seq_even  = wr_en & wr_data[BIT_SEQ_EVEN];
        cmd.seq_odd   = wr_en & wr_data[BIT_SEQ_ODD];
        cmd.dis_req   = wr_en & wr_data[BIT_DIS];
        cmd.en_req    = wr_en & wr_data[BIT_EN];
    end

endmodule

// File: rtl/usb_inep_flags.sv
// Module: usb_inep_flags
// Holds the software-owned endpoint state: stall, FIFO number, NAK state
// and data-sequence bit. Set strobes win over clear strobes.
// Assumes a synchronous active-low reset.
module usb_inep_flags
    import usb_inep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  inep_cmd_t         cmd,
    output logic              stall,
    output logic [FIFO_W-1:0] fifo_num,
    output logic              nak,
    output logic              seq
);

    // Load stall and FIFO number on writes, apply NAK and sequence strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall    <= 1'b0;
            fifo_num <= '0;
            nak      <= 1'b0;
            seq      <= 1'b0;
        end else begin
            if (cmd.wr) begin
                stall    <= cmd.stall_val;
                fifo_num <= cmd.fifo_val;
            end
            if (cmd.nak_set)
                nak <= 1'b1;
            else if (cmd.nak_clr)
                nak <= 1'b0;
            if (cmd.seq_odd)
                seq <= 1'b1;
            else if (cmd.seq_even)
                seq <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_inep_en_ctl.sv
// Module: usb_inep_en_ctl
// Owns the enable bit and the ordered disable sequence. Engine events clear
// enable ahead of a software set. Once acknowledged, a disable request drops
// enable, then disable, then pulses the done interrupt for one cycle.
// Assumes engine events are single-cycle pulses.
module usb_inep_en_ctl
    import usb_inep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  inep_cmd_t cmd,
    input  logic      ev_setup_done,
    input  logic      ev_xfer_done,
    input  logic      ev_disable_ack,
    output logic      en,
    output logic      dis,
    output logic      done_irq
);

    shut_state_t st, st_nxt;
    logic        hw_clr;
    logic        en_nxt;

    // Any engine completion or the shutdown step removes enable
    assign hw_clr = ev_setup_done | ev_xfer_done | (st == SH_DROP_EN);

    // Disable reads set until its own step of the sequence has passed
    assign dis = (st == SH_PEND) | (st == SH_DROP_EN) | (st == SH_DROP_DIS);

    // Next enable value: hardware clear has priority
    always_comb begin
        en_nxt = en;
        if (hw_clr)
            en_nxt = 1'b0;
        else if (cmd.en_req)
            en_nxt = 1'b1;
    end

    // Next shutdown step
    always_comb begin
        st_nxt = st;
        unique case (st)
            SH_IDLE:     if (cmd.dis_req && en) st_nxt = SH_PEND;
            SH_PEND:     if (ev_disable_ack)    st_nxt = SH_DROP_EN;
            SH_DROP_EN:  st_nxt = SH_DROP_DIS;
            SH_DROP_DIS: st_nxt = SH_RAISE;
            SH_RAISE:    st_nxt = SH_IDLE;
            default:     st_nxt = SH_IDLE;
        endcase
    end

    // State registers and registered interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            st       <= SH_IDLE;
            done_irq <= 1'b0;
        end else begin
            en       <= en_nxt;
            st       <= st_nxt;
            done_irq <= (st == SH_RAISE);
        end
    end

endmodule

// File: rtl/usb_in_ep_ctrl.sv
// Module: usb_in_ep_ctrl
// Control register of one USB device IN endpoint. Decodes bus writes and
// keeps the software-owned flags. Runs the enable/disable handshake with the
// endpoint engine and assembles the read value.
// Assumes a synchronous active-low reset and single-cycle write strobes.
module usb_in_ep_ctrl
    import usb_inep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_setup_done,
    input  logic             ev_xfer_done,
    input  logic             ev_disable_ack,
    output logic             stall_active,
    output logic             nak_active,
    output logic             seq_odd,
    output logic             dis_done_irq
);

    inep_cmd_t         cmd;
    logic [FIFO_W-1:0] fifo_num;
    logic              en_bit;
    logic              dis_bit;

    usb_inep_cmd_dec u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    usb_inep_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .stall    (stall_active),
        .fifo_num (fifo_num),
        .nak      (nak_active),
        .seq      (seq_odd)
    );

    usb_inep_en_ctl u_en (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd            (cmd),
        .ev_setup_done  (ev_setup_done),
        .ev_xfer_done   (ev_xfer_done),
        .ev_disable_ack (ev_disable_ack),
        .en             (en_bit),
        .dis            (dis_bit),
        .done_irq       (dis_done_irq)
    );

    // Read value: stored fields only, strobe and spare bits read 0
    always_comb begin
        rd_data                    = '0;
        rd_data[BIT_STALL]         = stall_active;
        rd_data[FIFO_MSB:FIFO_LSB] = fifo_num;
        rd_data[BIT_DIS]           = dis_bit;
        rd_data[BIT_EN]            = en_bit;
    end

endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
// Module: usb_in_ep_ctrl_chk
// Temporal checks on the endpoint control register, bound to its top.
// Observes ports only.
module usb_in_ep_ctrl_chk
    import usb_inep_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic             ev_setup_done,
    input logic             ev_xfer_done,
    input logic             stall_active,
    input logic             nak_active,
    input logic             seq_odd,
    input logic             dis_done_irq
);

    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(stall_active) && $stable(rd_data[FIFO_MSB:FIFO_LSB])
                    && $stable(nak_active) && $stable(seq_odd)));

    p_hw_clear_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_done || ev_xfer_done) |=> !rd_data[BIT_EN]);

    p_dis_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[BIT_DIS]) |-> $past(rd_data[BIT_EN]));

    p_irq_after_dis_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[BIT_DIS]) |=> dis_done_irq);

    p_irq_dis_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dis_done_irq |-> !rd_data[BIT_DIS]);

    p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dis_done_irq |=> !dis_done_irq);

endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .ev_setup_done (ev_setup_done),
    .ev_xfer_done  (ev_xfer_done),
    .stall_active  (stall_active),
    .nak_active    (nak_active),
    .seq_odd       (seq_odd),
    .dis_done_irq  (dis_done_irq)
);

// File: tb/usb_in_ep_ctrl_test.sv
// Bench for usb_in_ep_ctrl: sweeps field values and command combinations,
// then steps the disable chain edge by edge.
module usb_in_ep_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_setup_done = 1'b0;
    logic        ev_xfer_done = 1'b0;
    logic        ev_disable_ack = 1'b0;
    logic        stall_active, nak_active, seq_odd, dis_done_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    usb_in_ep_ctrl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .ev_setup_done  (ev_setup_done),
        .ev_xfer_done   (ev_xfer_done),
        .ev_disable_ack (ev_disable_ack),
        .stall_active   (stall_active),
        .nak_active     (nak_active),
        .seq_odd        (seq_odd),
        .dis_done_irq   (dis_done_irq)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
        wr_data = 32'hFFFF_FFFF;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] exp_rd;
        logic        init_v, exp_v;
        // R1: reset state
        tick(); tick(); tick();
        check("R1 rd", rd_data, 32'h0);
        check("R1 nak/seq/irq", {29'b0, nak_active, seq_odd, dis_done_irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R6: stall and FIFO sweep, low and strobe-free bits forced high
        for (int v = 0; v < 32; v++) begin
            wr((32'(v[3:0]) << 22) | (32'(v[4]) << 21) | 32'h001F_FFFF);
            exp_rd = (32'(v[3:0]) << 22) | (32'(v[4]) << 21);
            check("R2 R3 R6 readback", rd_data, exp_rd);
            check("R2 stall_active", {31'b0, stall_active}, {31'b0, v[4]});
            tick();
            check("R2 R3 hold without write", rd_data, exp_rd);
        end

        // R4: NAK strobe combinations from both start values (bit27 set, bit26 clr)
        for (int i = 0; i < 2; i++) begin
            for (int c = 0; c < 4; c++) begin
                init_v = i[0];
                wr(init_v ? 32'h0800_0000 : 32'h0400_0000);
                wr(32'(c[1:0]) << 26);
                exp_v = c[1] ? 1'b1 : (c[0] ? 1'b0 : init_v);
                check("R4 nak_active", {31'b0, nak_active}, {31'b0, exp_v});
                check("R6 strobes read 0", {28'b0, rd_data[29:26]}, 32'h0);
            end
        end

        // R5: sequence strobe combinations (bit29 odd, bit28 even)
        for (int i = 0; i < 2; i++) begin
            for (int c = 0; c < 4; c++) begin
                init_v = i[0];
                wr(init_v ? 32'h2000_0000 : 32'h1000_0000);
                wr(32'(c[1:0]) << 28);
                exp_v = c[1] ? 1'b1 : (c[0] ? 1'b0 : init_v);
                check("R5 seq_odd", {31'b0, seq_odd}, {31'b0, exp_v});
                check("R6 strobes read 0", {28'b0, rd_data[29:26]}, 32'h0);
            end
        end

        // R7: enable set by 1, unaffected by 0
        wr(32'h8000_0000);
        check("R7 enable set", {31'b0, rd_data[31]}, 32'h1);
        wr(32'h0000_0000);
        check("R7 write 0 keeps enable", {31'b0, rd_data[31]}, 32'h1);

        // R8: every event combination, with and without a same-cycle software set
        for (int e = 0; e < 4; e++) begin
            for (int s = 0; s < 2; s++) begin
                wr(32'h8000_0000);
                ev_setup_done = e[0];
                ev_xfer_done  = e[1];
                wr_en   = 1'b1;
                wr_data = s[0] ? 32'h8000_0000 : 32'h0;
                tick();
                wr_en = 1'b0;
                ev_setup_done = 1'b0;
                ev_xfer_done  = 1'b0;
                check("R8 enable after event", {31'b0, rd_data[31]},
                      {31'b0, (e == 0)});
            end
        end

        // R9: disable ignored while enable is 0 or when 0 is written
        ev_xfer_done = 1'b1; tick(); ev_xfer_done = 1'b0;
        wr(32'h4000_0000);
        check("R9 disable ignored with enable 0", {30'b0, rd_data[31:30]}, 32'h0);
        wr(32'h8000_0000);
        wr(32'h0000_0000);
        check("R9 write 0 to disable", {30'b0, rd_data[31:30]}, 32'h2);

        // R10: acknowledge while idle is ignored
        ev_disable_ack = 1'b1; tick(); ev_disable_ack = 1'b0;
        check("R10 idle ack ignored", {30'b0, rd_data[31:30]}, 32'h2);
        tick(); tick(); tick();
        check("R10 idle ack no irq", {31'b0, dis_done_irq}, 32'h0);

        // R9 R10 R11: full disable chain, edge by edge
        wr(32'h4000_0000);
        check("R9 disable set", {30'b0, rd_data[31:30]}, 32'h3);
        tick();
        check("R10 pending holds", {30'b0, rd_data[31:30]}, 32'h3);
        ev_disable_ack = 1'b1; tick(); ev_disable_ack = 1'b0;
        check("R10 edge k", {29'b0, rd_data[31:30], dis_done_irq}, 32'h6);
        tick();
        check("R10 edge k+1 enable dropped", {29'b0, rd_data[31:30], dis_done_irq}, 32'h2);
        tick();
        check("R10 edge k+2 disable dropped", {29'b0, rd_data[31:30], dis_done_irq}, 32'h0);
        tick();
        check("R11 edge k+3 irq", {29'b0, rd_data[31:30], dis_done_irq}, 32'h1);
        tick();
        check("R11 irq single cycle", {31'b0, dis_done_irq}, 32'h0);

        // R1: reset from a busy state
        wr(32'hABFF_FFFF);
        wr(32'h4000_0000);
        rst_n = 1'b0;
        tick();
        check("R1 reset mid-run rd", rd_data, 32'h0);
        check("R1 reset mid-run flags", {29'b0, nak_active, seq_odd, dis_done_irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        finish_run();
    end

endmodule